// File: doc/BRIEF.md
# Triple-Copy Integer Register File

This block holds the general-purpose integer registers of a small 32-bit core: 32 entries of 32 bits, where entry 0 is a constant zero. A single write port takes a value from the destination bus at a rising clock edge. Two independent read ports put register contents on source bus 1 and source bus 2. The index fields for the write port and the two read ports are 5 bits wide. They are meant to be wired directly to fixed slices of the instruction word: destination at bits 11:7, first source at bits 19:15, second source at bits 24:20.

Each write updates three parallel copies of the register at once: one copy feeds source bus 1, one feeds source bus 2, and one feeds a flat status vector with a 32-bit slice per register, intended to drive indicator lamps. Each source bus has its own output enable. A selected value can therefore appear on bus 1 only, bus 2 only, both, or neither. A disabled bus reads as all zeros rather than floating.

Top module: `xreg_tri`

## Requirements
- R1: When `dst_we` is high at a rising edge of `clk` and `dst_idx` is nonzero, `dst_data` is stored in that register. When `dst_we` is low, no register changes.
- R2: Register 0 reads as zero on both ports, and a write to index 0 changes nothing. Slice 0 of `led_view` is always zero.
- R3: `src1_data` and `src2_data` follow `src1_idx` and `src2_idx` combinationally, and the two indexes are independent of each other.
- R4: A source port whose output enable is low drives all zeros, whatever its index.
- R5: Bits [32*i+31 : 32*i] of `led_view` show register i continuously. That slice is updated at the same edge as the read copies.
- R6: Both ports may select the same register in the same cycle, and both then show the same value.
- R7: A read of the register being written in that cycle returns the old value. The new value appears only after the edge.
- R8: A synchronous active-high `rst` clears every register and every display slice to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dst_we | input | 1 | Write enable |
| dst_idx | input | 5 | Destination register index |
| dst_data | input | 32 | Destination bus value |
| src1_idx | input | 5 | Source 1 register index |
| src1_oe | input | 1 | Source bus 1 output enable |
| src1_data | output | 32 | Source bus 1 |
| src2_idx | input | 5 | Source 2 register index |
| src2_oe | input | 1 | Source bus 2 output enable |
| src2_data | output | 32 | Source bus 2 |
| led_view | output | 1024 | Display copies, 32 bits per register, register i at bit 32*i |

## Verification
A write and a read of the same register can fall in the same cycle. The bench provokes this with a directed case that writes a register while both ports select it. It then samples the ports before the edge, where they must show the old value, and again after the edge, where they must show the new one. The random phase also hits this collision by chance. In every cycle it compares both ports before the edge, and all display slices after it, against a reference array that the bench updates only at the edge.

// File: rtl/xreg_tri.sv
module xreg_tri #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int IW = $clog2(NREG)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 dst_we,
  input  logic [IW-1:0]        dst_idx,
  input  logic [XLEN-1:0]      dst_data,
  input  logic [IW-1:0]        src1_idx,
  input  logic                 src1_oe,
  output logic [XLEN-1:0]      src1_data,
  input  logic [IW-1:0]        src2_idx,
  input  logic                 src2_oe,
  output logic [XLEN-1:0]      src2_data,
  output logic [NREG*XLEN-1:0] led_view
);

  logic [XLEN-1:0] copy_a [NREG];
  logic [XLEN-1:0] copy_b [NREG];
  logic [XLEN-1:0] copy_v [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign copy_a[i] = '0;
      assign copy_b[i] = '0;
      assign copy_v[i] = '0;
    end else begin : g_store
      logic hit;
      assign hit = dst_we && (dst_idx == IW'(i));
      always_ff @(posedge clk) begin
        if (rst) begin
          copy_a[i] <= '0;
          copy_b[i] <= '0;
          copy_v[i] <= '0;
        end else if (hit) begin
          copy_a[i] <= dst_data;
          copy_b[i] <= dst_data;
          copy_v[i] <= dst_data;
        end
      end
    end
    assign led_view[i*XLEN +: XLEN] = copy_v[i];
  end

  assign src1_data = src1_oe ? copy_a[src1_idx] : '0;
  assign src2_data = src2_oe ? copy_b[src2_idx] : '0;

endmodule

// File: rtl/xreg_tri_chk.sv
module xreg_tri_chk #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int IW = $clog2(NREG)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 dst_we,
  input logic [IW-1:0]        dst_idx,
  input logic [XLEN-1:0]      dst_data,
  input logic [IW-1:0]        src1_idx,
  input logic                 src1_oe,
  input logic [XLEN-1:0]      src1_data,
  input logic [IW-1:0]        src2_idx,
  input logic                 src2_oe,
  input logic [XLEN-1:0]      src2_data,
  input logic [NREG*XLEN-1:0] led_view
);

  a_r2_zero_reg: assert property (@(posedge clk) disable iff (rst)
    (src1_oe && src1_idx == '0) |-> (src1_data == '0 && led_view[XLEN-1:0] == '0));

  a_r4_port1_off: assert property (@(posedge clk) disable iff (rst)
    !src1_oe |-> src1_data == '0);

  a_r4_port2_off: assert property (@(posedge clk) disable iff (rst)
    !src2_oe |-> src2_data == '0);

  a_r1_write_lands: assert property (@(posedge clk) disable iff (rst)
    (dst_we && dst_idx != '0) |=> led_view[$past(dst_idx)*XLEN +: XLEN] == $past(dst_data));

  a_r5_view_matches_port: assert property (@(posedge clk) disable iff (rst)
    src1_oe |-> src1_data == led_view[src1_idx*XLEN +: XLEN]);

  a_r6_ports_agree: assert property (@(posedge clk) disable iff (rst)
    (src1_oe && src2_oe && src1_idx == src2_idx) |-> src1_data == src2_data);

  a_r1_no_wen_stable: assert property (@(posedge clk) disable iff (rst)
    !dst_we |=> $stable(led_view));

endmodule

bind xreg_tri xreg_tri_chk #(.XLEN(XLEN), .NREG(NREG)) u_chk (
  .clk(clk), .rst(rst), .dst_we(dst_we), .dst_idx(dst_idx), .dst_data(dst_data),
  .src1_idx(src1_idx), .src1_oe(src1_oe), .src1_data(src1_data),
  .src2_idx(src2_idx), .src2_oe(src2_oe), .src2_data(src2_data),
  .led_view(led_view)
);

// File: tb/sim_xreg_tri.sv
`timescale 1ns/1ps
module sim_xreg_tri;
  localparam int W = 32;
  localparam int N = 32;

  logic clk = 0, rst = 1, dst_we = 0, src1_oe = 0, src2_oe = 0;
  logic [4:0] dst_idx = 0, src1_idx = 0, src2_idx = 0;
  logic [W-1:0] dst_data = 0;
  logic [W-1:0] src1_data, src2_data;
  logic [N*W-1:0] led_view;

  logic [W-1:0] model [N];
  int n_chk = 0, n_fail = 0;

  xreg_tri u0 (.clk(clk), .rst(rst), .dst_we(dst_we), .dst_idx(dst_idx), .dst_data(dst_data),
    .src1_idx(src1_idx), .src1_oe(src1_oe), .src1_data(src1_data),
    .src2_idx(src2_idx), .src2_oe(src2_oe), .src2_data(src2_data), .led_view(led_view));

  always #2 clk = ~clk;

  task automatic chk(string tag, logic [W-1:0] got, logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic chk_view(string tag);
    int bad = -1;
    n_chk++;
    for (int i = 0; i < N; i++)
      if (led_view[i*W +: W] !== model[i] && bad < 0) bad = i;
    if (bad >= 0) begin
      n_fail++;
      $display("FAIL %s view[%0d] got=%h exp=%h", tag, bad, led_view[bad*W +: W], model[bad]);
    end
  endtask

  function automatic logic [W-1:0] expect_rd(logic oe, logic [4:0] idx);
    return oe ? model[idx] : '0;
  endfunction

  // drive at negedge, check ports before the edge, check display after it
  task automatic cycle(logic we, logic [4:0] wi, logic [W-1:0] wd,
                       logic o1, logic [4:0] i1, logic o2, logic [4:0] i2, string tag);
    @(negedge clk);
    dst_we = we; dst_idx = wi; dst_data = wd;
    src1_oe = o1; src1_idx = i1; src2_oe = o2; src2_idx = i2;
    #1;
    chk({tag, " R3 port1"}, src1_data, expect_rd(o1, i1));
    chk({tag, " R3 port2"}, src2_data, expect_rd(o2, i2));
    @(posedge clk);
    if (we && wi != 0) model[wi] = wd;
    #1;
    chk_view({tag, " R5"});
  endtask

  task automatic do_reset(string tag);
    @(negedge clk);
    rst = 1; dst_we = 0;
    @(posedge clk); @(negedge clk);
    rst = 0;
    for (int i = 0; i < N; i++) model[i] = '0;
    #0.5;
    chk_view({tag, " R8 clear"});
    src1_oe = 1; src2_oe = 1; src1_idx = 17; src2_idx = 31; #0.5;
    chk({tag, " R8 port1"}, src1_data, '0);
    chk({tag, " R8 port2"}, src2_data, '0);
  endtask

  task automatic t_basic;
    cycle(1, 5, 32'hCAFE_0005, 0, 0, 0, 0, "basic");
    cycle(1, 31, 32'h8000_001F, 1, 5, 1, 5, "basic R1 R6");
    cycle(0, 0, 0, 1, 31, 1, 5, "basic R1 R3");
    chk("basic R1 x31", led_view[31*W +: W], 32'h8000_001F);
  endtask

  task automatic t_no_wen;
    cycle(0, 5, 32'hDEAD_BEEF, 1, 5, 0, 0, "nowen R1");
    cycle(0, 0, 0, 1, 5, 0, 0, "nowen R1");
    chk("nowen R1 x5 kept", src1_data, 32'hCAFE_0005);
  endtask

  task automatic t_zero;
    cycle(1, 0, 32'hFFFF_FFFF, 1, 0, 1, 0, "x0 R2");
    cycle(0, 0, 0, 1, 0, 1, 0, "x0 R2");
    chk("x0 R2 port1", src1_data, '0);
    chk("x0 R2 view", led_view[W-1:0], '0);
  endtask

  task automatic t_oe;
    cycle(0, 0, 0, 1, 5, 0, 5, "oe R4 bus1 only");
    chk("oe R4 port2 off", src2_data, '0);
    cycle(0, 0, 0, 0, 5, 1, 5, "oe R4 bus2 only");
    chk("oe R4 port1 off", src1_data, '0);
    cycle(0, 0, 0, 1, 5, 1, 31, "oe R4 both");
    cycle(0, 0, 0, 0, 5, 0, 31, "oe R4 neither");
  endtask

  task automatic t_collide;
    @(negedge clk);
    dst_we = 1; dst_idx = 7; dst_data = 32'h1111_0007;
    src1_oe = 1; src1_idx = 7; src2_oe = 1; src2_idx = 7;
    @(posedge clk); model[7] = 32'h1111_0007;
    @(negedge clk);
    dst_data = 32'h2222_0007; #1;
    chk("collide R7 old port1", src1_data, 32'h1111_0007);
    chk("collide R7 old port2", src2_data, 32'h1111_0007);
    @(posedge clk); model[7] = 32'h2222_0007;
    @(negedge clk); dst_we = 0; #1;
    chk("collide R7 new port1", src1_data, 32'h2222_0007);
    chk("collide R7 new port2", src2_data, 32'h2222_0007);
    chk_view("collide R7 R5 view");
  endtask

  task automatic t_random;
    for (int k = 0; k < 400; k++)
      cycle(1'($urandom), 5'($urandom), $urandom, 1'($urandom), 5'($urandom),
            1'($urandom), 5'($urandom), "rand");
  endtask

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) model[i] = '0;
    do_reset("reset");
    t_basic();
    t_no_wen();
    t_zero();
    t_oe();
    t_collide();
    t_random();
    do_reset("reset2");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule